// File: doc/BRIEF.md
# Vector Lane Address Generator

This block forms one memory address per lane across a wide vector. It takes two vector operands. The first supplies a base address in every lane. The second supplies an offset in every lane, which is extended, scaled by a power of two and then added to the base. Each lane wraps at its own width, and no carry passes into the next lane. Every lane of the result is produced, with no per-lane enable.

The offset can be used in one of three ways. In packed operation the lanes are 32 or 64 bits wide, and the whole offset lane is taken as an unsigned number. In the two unpacked operations the lanes are always 64 bits wide. Only the low 32 bits of each offset lane are used, and they are either sign-extended or zero-extended to 64 bits.

The sum is computed without any clock. It is captured by a single output register that sits behind a valid/ready handshake, so a result appears one cycle after its operands are accepted. The controls travel with the operands and are sampled in the same cycle.

Top module: `vag_top`

## Requirements
- R1: In packed operation `size_sel`=0 gives 32-bit lanes and `size_sel`=1 gives 64-bit lanes. There are `VEC_W`/width lanes, and lane 0 sits in the least significant bits of every vector.
- R2: `mode`=2'b00 is packed operation. The full offset lane is read as an unsigned value with no extension.
- R3: `mode`=2'b01 is unpacked signed operation. Bits 31:0 of each 64-bit offset lane are sign-extended to 64 bits.
- R4: `mode`=2'b10 is unpacked unsigned operation. Bits 31:0 of each 64-bit offset lane are zero-extended to 64 bits.
- R5: In both unpacked modes the lanes are 64 bits wide whatever the value of `size_sel`, and bits 63:32 of each offset lane have no effect on the result.
- R6: The extended offset is multiplied by 2 to the power `amount` (1, 2, 4 or 8) before the add.
- R7: Each result lane equals base + scaled offset, kept to the lane width. The add wraps, and no carry reaches a neighbouring lane.
- R8: Every lane of `addr_vec` is written on every accepted operation.
- R9: `mode`=2'b11 behaves exactly like packed operation.
- R10: A transfer is accepted on a clock edge where both `in_valid` and `in_ready` are high. `out_valid` is high from the next cycle, and `addr_vec` then holds the result of the operands and controls present at the accepting edge.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `addr_vec` do not change. While `out_valid` is low, `in_ready` is high.
- R12: After reset `out_valid` is 0, `in_ready` is 1 and `addr_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are present |
| in_ready | output | 1 | Block can take an operation this cycle |
| mode | input | 2 | Offset handling: 00 packed, 01 unpacked signed, 10 unpacked unsigned, 11 packed |
| size_sel | input | 1 | Packed lane width: 0 selects 32 bits, 1 selects 64 bits |
| amount | input | 2 | Offset shift count, 0 to 3 |
| base_vec | input | VEC_W | Base address lanes |
| offs_vec | input | VEC_W | Offset lanes |
| out_valid | output | 1 | `addr_vec` holds a result |
| out_ready | input | 1 | Consumer takes the result |
| addr_vec | output | VEC_W | Computed address lanes |

## Verification
The hardest case to reach is a new operation waiting at the input while an earlier result is held by back-pressure. The bench must show that the waiting operand neither disturbs the held result nor gets accepted early, and that it is taken on the same edge that releases the stall. The stimulus holds `out_ready` low and keeps a second operand valid for several cycles, then raises `out_ready` while that operand is still asserted. The table also places sign-bit offsets under the largest shift, and bases near the top of a lane, so that every wrap happens next to a lane boundary.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    VAG_PACKED     = 2'b00,
    VAG_UNP_SX     = 2'b01,
    VAG_UNP_ZX     = 2'b10,
    VAG_PACKED_ALT = 2'b11
  } vag_mode_e;

  typedef struct packed {
    vag_mode_e   mode;
    logic        size64;
    logic [1:0]  amt;
  } vag_ctrl_t;

  // true when the lanes must be 64 bits whatever the size select says
  function automatic logic vag_is_unpacked(input vag_mode_e m);
    return (m == VAG_UNP_SX) || (m == VAG_UNP_ZX);
  endfunction

  // offset extension for a 64-bit lane
  function automatic logic [63:0] vag_extend64(input logic [63:0] raw,
                                               input vag_mode_e   m);
    logic [63:0] r;
    case (m)
      VAG_UNP_SX: r = {{32{raw[31]}}, raw[31:0]};
      VAG_UNP_ZX: r = {32'h0, raw[31:0]};
      default:    r = raw;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] vag_sum64(input logic [63:0] base,
                                            input logic [63:0] off,
                                            input logic [1:0]  amt);
    return base + (off << amt);
  endfunction

  function automatic logic [31:0] vag_sum32(input logic [31:0] base,
                                            input logic [31:0] off,
                                            input logic [1:0]  amt);
    return base + (off << amt);
  endfunction

endpackage

// File: rtl/vag_lane64.sv
module vag_lane64
  import vag_pkg::*;
(
  input  logic [63:0] base_i,
  input  logic [63:0] off_i,
  input  vag_mode_e   mode_i,
  input  logic [1:0]  amt_i,
  output logic [63:0] sum_o
);
  logic [63:0] ext_off;

  always_comb begin
    ext_off = vag_extend64(off_i, mode_i);
    sum_o   = vag_sum64(base_i, ext_off, amt_i);
  end
endmodule

// File: rtl/vag_lane32.sv
module vag_lane32
  import vag_pkg::*;
(
  input  logic [31:0] base_i,
  input  logic [31:0] off_i,
  input  logic [1:0]  amt_i,
  output logic [31:0] sum_o
);
  always_comb sum_o = vag_sum32(base_i, off_i, amt_i);
endmodule

// File: rtl/vag_datapath.sv
module vag_datapath
  import vag_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic [VEC_W-1:0] base_i,
  input  logic [VEC_W-1:0] offs_i,
  input  vag_ctrl_t        ctrl_i,
  output logic             wide_o,
  output logic [VEC_W-1:0] sum_o
);
  localparam int N64 = VEC_W / 64;
  localparam int N32 = VEC_W / 32;

  logic [VEC_W-1:0] sum64;
  logic [VEC_W-1:0] sum32;

  for (genvar g = 0; g < N64; g++) begin : g_l64
    vag_lane64 u_lane (
      .base_i (base_i[g*64 +: 64]),
      .off_i  (offs_i[g*64 +: 64]),
      .mode_i (ctrl_i.mode),
      .amt_i  (ctrl_i.amt),
      .sum_o  (sum64[g*64 +: 64])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_l32
    vag_lane32 u_lane (
      .base_i (base_i[g*32 +: 32]),
      .off_i  (offs_i[g*32 +: 32]),
      .amt_i  (ctrl_i.amt),
      .sum_o  (sum32[g*32 +: 32])
    );
  end

  always_comb begin
    wide_o = vag_is_unpacked(ctrl_i.mode) || ctrl_i.size64;
    sum_o  = wide_o ? sum64 : sum32;
  end
endmodule

// File: rtl/vag_outreg.sv
module vag_outreg #(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  input  logic [VEC_W-1:0] d_i,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] q_o
);
  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_o       <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      q_o       <= d_i;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vag_top.sv
module vag_top
  import vag_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       mode,
  input  logic             size_sel,
  input  logic [1:0]       amount,
  input  logic [VEC_W-1:0] base_vec,
  input  logic [VEC_W-1:0] offs_vec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] addr_vec
);
  vag_ctrl_t        ctrl;
  logic             accept;
  logic             wide_sel;
  logic [VEC_W-1:0] comb_sum;

  always_comb begin
    ctrl.mode   = vag_mode_e'(mode);
    ctrl.size64 = size_sel;
    ctrl.amt    = amount;
  end

  vag_datapath #(.VEC_W(VEC_W)) u_dp (
    .base_i (base_vec),
    .offs_i (offs_vec),
    .ctrl_i (ctrl),
    .wide_o (wide_sel),
    .sum_o  (comb_sum)
  );

  vag_outreg #(.VEC_W(VEC_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .d_i       (comb_sum),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_o       (addr_vec)
  );
endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             accept,
  input logic             wide_sel,
  input logic [1:0]       mode,
  input logic [1:0]       amount,
  input logic [63:0]      base_lo,
  input logic [31:0]      offs_lo,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] addr_vec
);
  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(addr_vec)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R5
  unpacked_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b10) |-> wide_sel);

  // R4
  zx_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b10) |=>
      (addr_vec[63:0] == $past(base_lo) + ({32'h0, $past(offs_lo)} << $past(amount))));
endmodule

bind vag_top vag_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .accept    (accept),
  .wide_sel  (wide_sel),
  .mode      (mode),
  .amount    (amount),
  .base_lo   (base_vec[63:0]),
  .offs_lo   (offs_vec[31:0]),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .addr_vec  (addr_vec)
);

// File: tb/tb_vag_top.sv
module tb_vag_top;
  localparam int VEC_W = 256;
  localparam int NCH   = VEC_W / 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       mode = 2'b00;
  logic             size_sel = 1'b0;
  logic [1:0]       amount = 2'b00;
  logic [VEC_W-1:0] base_vec = '0;
  logic [VEC_W-1:0] offs_vec = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VEC_W-1:0] addr_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vag_top #(.VEC_W(VEC_W)) dut (.*);

  typedef struct packed {
    logic [1:0]  md;
    logic        sz;
    logic [1:0]  am;
    logic [63:0] bseed;
    logic [63:0] oseed;
  } vec_t;

  localparam int NT = 10;
  localparam vec_t TBL [0:NT-1] = '{
    '{2'b00, 1'b0, 2'd0, 64'h0000_1000_0000_2000, 64'h0000_0003_0000_0004},
    '{2'b00, 1'b0, 2'd3, 64'hFFFF_FFF0_FFFF_FFF0, 64'h0000_0010_0000_0002},
    '{2'b00, 1'b1, 2'd2, 64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0001},
    '{2'b00, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF000_0000_0000_0001},
    '{2'b01, 1'b1, 2'd0, 64'h0000_0000_0001_0000, 64'h0000_0000_FFFF_FFFF},
    '{2'b01, 1'b0, 2'd3, 64'h0000_0000_0000_0100, 64'hDEAD_BEEF_8000_0000},
    '{2'b10, 1'b1, 2'd1, 64'h0000_0001_0000_0000, 64'hDEAD_BEEF_8000_0000},
    '{2'b10, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{2'b11, 1'b0, 2'd1, 64'h7FFF_FFFF_7FFF_FFFF, 64'h8000_0001_8000_0001},
    '{2'b11, 1'b1, 2'd2, 64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000}
  };

  // build a vector whose 64-bit chunks differ from lane to lane
  function automatic logic [VEC_W-1:0] spread(input logic [63:0] seed, input logic [63:0] step);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int i = 0; i < NCH; i++) v[i*64 +: 64] = seed + step * i;
    return v;
  endfunction

  // reference: per-lane arithmetic in 128 bits, then keep the lane width
  function automatic logic [VEC_W-1:0] ref_model(input logic [1:0] md, input logic sz,
                                                 input logic [1:0] am,
                                                 input logic [VEC_W-1:0] bv,
                                                 input logic [VEC_W-1:0] ov);
    logic [VEC_W-1:0] res;
    int w;
    w = (md == 2'b01 || md == 2'b10) ? 64 : (sz ? 64 : 32);
    res = '0;
    for (int l = 0; l < VEC_W / w; l++) begin
      logic [127:0] b, o, r;
      b = 128'(bv >> (l * w));
      o = 128'(ov >> (l * w));
      if (w == 32) begin
        b[127:32] = '0;
        o[127:32] = '0;
      end else begin
        b[127:64] = '0;
        o[127:64] = '0;
      end
      if (md == 2'b01) o = {{96{o[31]}}, o[31:0]};
      else if (md == 2'b10) o = {96'h0, o[31:0]};
      r = b + o * (128'd1 << am);
      for (int k = 0; k < w; k++) res[l * w + k] = r[k];
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] md, input logic sz, input logic [1:0] am,
                       input logic [VEC_W-1:0] bv, input logic [VEC_W-1:0] ov);
    mode = md; size_sel = sz; amount = am; base_vec = bv; offs_vec = ov;
    in_valid = 1'b1;
  endtask

  // accept one operation with out_ready high and return the output seen after it
  task automatic run_one(input logic [1:0] md, input logic sz, input logic [1:0] am,
                         input logic [VEC_W-1:0] bv, input logic [VEC_W-1:0] ov,
                         output logic [VEC_W-1:0] got, output logic vld);
    @(negedge clk);
    drive(md, sz, am, bv, ov);
    @(negedge clk);
    in_valid = 1'b0;
    got = addr_vec;
    vld = out_valid;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [VEC_W-1:0] got, got2, exp, bv, ov, a_res, b_res;
    logic vld;

    // R12: reset state
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12 reset handshake",
          VEC_W'({out_valid, in_ready}), VEC_W'(2'b01));
    check(addr_vec == '0, "R12 reset data", addr_vec, '0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R6 R7 R8 R9 R10: table walk, every lane compared
    for (int t = 0; t < NT; t++) begin
      bv  = spread(TBL[t].bseed, 64'h0101_0101_0101_0101);
      ov  = spread(TBL[t].oseed, 64'h0000_0011_0000_0011);
      exp = ref_model(TBL[t].md, TBL[t].sz, TBL[t].am, bv, ov);
      run_one(TBL[t].md, TBL[t].sz, TBL[t].am, bv, ov, got, vld);
      check(vld == 1'b1, "R10 valid after accept", VEC_W'(vld), VEC_W'(1));
      check(got == exp, "R1/R2/R3/R4/R6/R7/R8/R9 table lanes", got, exp);
    end

    // R10: with nothing offered and out_ready high, valid drops
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid drops when consumed",
          VEC_W'(out_valid), VEC_W'(0));

    // R7: 32-bit lane wraps without disturbing lane 1
    bv = '0; ov = '0;
    bv[31:0] = 32'hFFFF_FFFF; ov[31:0] = 32'h0000_0001;
    exp = '0;
    run_one(2'b00, 1'b0, 2'd0, bv, ov, got, vld);
    check(got == exp, "R7 no carry across lanes", got, exp);

    // R3 R6: most negative offset under shift 3
    bv = '0; ov = '0;
    bv[63:0] = 64'h0000_0004_0000_0000; ov[63:0] = 64'h0000_0000_8000_0000;
    exp = '0; exp[63:0] = 64'h0000_0000_0000_0000;
    run_one(2'b01, 1'b1, 2'd3, bv, ov, got, vld);
    check(got == exp, "R3 R6 negative max offset", got, exp);

    // R5: upper offset bits and size select have no effect in unpacked modes
    bv = spread(64'h0000_0000_1000_0000, 64'h10);
    ov = spread(64'h0000_0000_8765_4321, 64'h0);
    run_one(2'b10, 1'b1, 2'd2, bv, ov, got, vld);
    for (int i = 0; i < NCH; i++) ov[i*64+32 +: 32] = 32'hA5A5_0000 + i;
    run_one(2'b10, 1'b0, 2'd2, bv, ov, got2, vld);
    check(got2 == got, "R5 unsigned upper bits and size ignored", got2, got);
    run_one(2'b01, 1'b1, 2'd1, bv, ov, got, vld);
    ov = spread(64'h0000_0000_8765_4321, 64'h0);
    run_one(2'b01, 1'b0, 2'd1, bv, ov, got2, vld);
    check(got2 == got, "R5 signed upper bits and size ignored", got2, got);

    // R11: back-pressure with a second operation waiting
    bv = spread(64'h1111_0000_2222_0000, 64'h1);
    ov = spread(64'h0000_0001_0000_0002, 64'h1);
    a_res = ref_model(2'b00, 1'b1, 2'd1, bv, ov);
    @(negedge clk);
    out_ready = 1'b0;
    drive(2'b00, 1'b1, 2'd1, bv, ov);
    @(negedge clk);
    check(in_ready == 1'b0, "R11 in_ready low while stalled",
          VEC_W'(in_ready), VEC_W'(0));
    bv = spread(64'h0000_0000_0000_0100, 64'h2);
    ov = spread(64'h0000_0000_FFFF_FFFE, 64'h0);
    b_res = ref_model(2'b01, 1'b0, 2'd2, bv, ov);
    drive(2'b01, 1'b0, 2'd2, bv, ov);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1 && addr_vec == a_res, "R11 result held under stall",
          addr_vec, a_res);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && addr_vec == b_res, "R11 waiting op taken on release",
          addr_vec, b_res);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 idle after drain",
          VEC_W'({out_valid, in_ready}), VEC_W'(2'b01));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule